// File: doc/BRIEF.md
# Dual-Mode Event Timer

This block counts either the ticks of a time base or edges on one of four external inputs. Each advance of the counter is compared against a programmable match value. When a step lands while the counter equals that value, a sticky flag is set, and that flag can drive an interrupt line. Software chooses one of two counter behaviours. In the first, the counter returns to zero on every match, which gives a periodic timer. In the second, it runs on past the match and wraps at its full width.

Software controls the block through a small word-wide register port. A single run bit acts as the synchronous reset of the counting logic: clearing it zeroes the counter, the prescaler and the flag. The settings that define the counting path (source, mode, edge sense, wrap behaviour and prescaler) are latched only while the block is stopped. This means a running count can never see its configuration change underneath it.

Top module: `evt_timer`

## Requirements
- R1: Register map, selected by `reg_addr`. Address 0 is control: bit0 run, bit1 source mode (0 = tick, 1 = edge), bit2 wrap mode (0 = zero on match, 1 = free running), bit3 edge invert, bits5:4 input select, bit6 interrupt enable, bit7 match flag. Address 1 is prescale: bits3:0 exponent N, bit4 bypass. Address 2 is the match value. Address 3 is the counter, which is read-only.
- R2: While run is 0, the counter and the flag read 0. Writing run to 0 zeroes both on the next clock.
- R3: In tick mode with bypass set, every cycle with `tick_i` high advances the counter by one.
- R4: In tick mode with bypass clear, the counter advances once per 2^(N+1) cycles that have `tick_i` high.
- R5: With wrap mode 0, a step taken while the counter equals the match value sets the flag and loads 0 into the counter.
- R6: With wrap mode 1, that same step sets the flag and the counter keeps incrementing. After 0xFFFF it wraps to 0.
- R7: Writing control with bit7 = 1 clears the flag. Writing bit7 = 0 leaves the flag unchanged. A match in the same cycle wins over the clear.
- R8: `irq_o` is high exactly when the flag and interrupt enable are both 1.
- R9: In edge mode, input-select codes 0, 1, 2 and 3 pick `pulse_i[0]`, `pulse_i[1]`, `pulse_i[2]` and `pulse_i[3]`. Edges on the other inputs are ignored.
- R10: With edge invert at 0, rising edges are counted. With edge invert at 1, falling edges are counted.
- R11: The input passes through two synchronizing flops. An edge is counted exactly once, however long the level is then held.
- R12: While run is 1, writes to mode, wrap, invert, select and prescale fields are ignored. The interrupt enable, the match value and the run bit stay writable.
- R13: A control write that sets run from 0 takes only run, interrupt enable and flag-clear. The configuration fields in that same write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| tick_i | input | 1 | Time-base strobe for tick mode |
| pulse_i | input | 4 | Asynchronous external event inputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the wrap from 0xFFFF to zero in free-running mode, because it needs 65 536 steps. The bench reaches it by holding `tick_i` high with the prescaler bypassed for a computed number of cycles, then reads the counter and checks that the flag stayed set. The configuration lock is also subtle: it is exercised by writes that try to change the mode while the block is running and in the same write that starts it, and each is followed by a read-back and a count that shows the old settings still hold.

// File: rtl/evt_timer_pkg.sv
// Package: shared widths, register addresses and control bit positions
// for the dual-mode event timer. Assumes a 16-bit register data path.
package evt_timer_pkg;
    parameter int CNT_W  = 16;
    parameter int NUM_IN = 4;
    parameter int SEL_W  = $clog2(NUM_IN);
    parameter int DIV_W  = 4;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_PRE  = 2'd1,
        A_CMP  = 2'd2,
        A_CNT  = 2'd3
    } reg_addr_e;

    localparam int B_RUN  = 0;
    localparam int B_MODE = 1;
    localparam int B_WRAP = 2;
    localparam int B_INV  = 3;
    localparam int B_SEL  = 4;
    localparam int B_IE   = 6;
    localparam int B_FLAG = 7;
    localparam int B_BYP  = 4;

    typedef struct packed {
        logic             pulse_mode;
        logic             free_run;
        logic             invert;
        logic [SEL_W-1:0] src_sel;
        logic             bypass;
        logic [DIV_W-1:0] div_exp;
    } cfg_t;
endpackage

// File: rtl/evt_timer_regs.sv
// Register file: holds run, interrupt enable, the locked counting
// configuration and the match value, and muxes read data.
// Assumes CNT_W is at least 8 so the control layout fits.
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         flag_i,
    input  logic [W-1:0] cnt_i,
    output logic         run_o,
    output logic         irq_en_o,
    output cfg_t         cfg_o,
    output logic [W-1:0] cmp_o,
    output logic         clr_o,
    output logic [W-1:0] rdata_o
);
    logic         run_q, ie_q;
    cfg_t         cfg_q;
    logic [W-1:0] cmp_q;
    logic         ctrl_wr, pre_wr, ctrl_open;

    assign ctrl_wr   = we_i && (addr_i == A_CTRL);
    assign pre_wr    = we_i && (addr_i == A_PRE);
    // configuration opens only when stopped and the write does not start the block
    assign ctrl_open = ctrl_wr && !run_q && !wdata_i[B_RUN];
    assign clr_o     = ctrl_wr && wdata_i[B_FLAG];

    // Purpose: run and interrupt-enable bits, always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (ctrl_wr) begin
            run_q <= wdata_i[B_RUN];
            ie_q  <= wdata_i[B_IE];
        end
    end

    // Purpose: counting configuration, updated only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (ctrl_open) begin
                cfg_q.pulse_mode <= wdata_i[B_MODE];
                cfg_q.free_run   <= wdata_i[B_WRAP];
                cfg_q.invert     <= wdata_i[B_INV];
                cfg_q.src_sel    <= wdata_i[B_SEL +: SEL_W];
            end
            if (pre_wr && !run_q) begin
                cfg_q.div_exp <= wdata_i[DIV_W-1:0];
                cfg_q.bypass  <= wdata_i[B_BYP];
            end
        end
    end

    // Purpose: match value, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n)                              cmp_q <= '0;
        else if (we_i && (addr_i == A_CMP))      cmp_q <= wdata_i;
    end

    // Purpose: read-data multiplexer
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[B_RUN]          = run_q;
                rdata_o[B_MODE]         = cfg_q.pulse_mode;
                rdata_o[B_WRAP]         = cfg_q.free_run;
                rdata_o[B_INV]          = cfg_q.invert;
                rdata_o[B_SEL +: SEL_W] = cfg_q.src_sel;
                rdata_o[B_IE]           = ie_q;
                rdata_o[B_FLAG]         = flag_i;
            end
            A_PRE: begin
                rdata_o[DIV_W-1:0] = cfg_q.div_exp;
                rdata_o[B_BYP]     = cfg_q.bypass;
            end
            A_CMP:   rdata_o = cmp_q;
            default: rdata_o = cnt_i;
        endcase
    end

    assign run_o    = run_q;
    assign irq_en_o = ie_q;
    assign cfg_o    = cfg_q;
    assign cmp_o    = cmp_q;

    // R12
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(cfg_q));

    // R13
    start_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata_i[B_RUN]) |=> $stable(cfg_q.pulse_mode) && $stable(cfg_q.free_run)
                                        && $stable(cfg_q.invert) && $stable(cfg_q.src_sel));
endmodule

// File: rtl/evt_timer_src.sv
// Step source: synchronizes the external inputs, picks one, detects the
// chosen edge, and divides the tick strobe by 2^(N+1) unless bypassed.
// Emits at most one step per clock and only while running.
module evt_timer_src
    import evt_timer_pkg::*;
#(
    parameter int N_IN = NUM_IN,
    parameter int SW   = SEL_W,
    parameter int DW   = DIV_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            pulse_mode_i,
    input  logic            invert_i,
    input  logic [SW-1:0]   src_sel_i,
    input  logic            bypass_i,
    input  logic [DW-1:0]   div_exp_i,
    input  logic            tick_i,
    input  logic [N_IN-1:0] pin_i,
    output logic            step_o
);
    localparam int PS_W = 2 ** DW;

    logic [N_IN-1:0] s1_q, s2_q;
    logic            lvl, prev_q, edge_hit;
    logic [PS_W-1:0] ps_q;
    logic [PS_W:0]   term_w;
    logic            ps_last;

    // Purpose: two-flop synchronizer per input, independent of run
    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q[g] <= 1'b0;
                s2_q[g] <= 1'b0;
            end else begin
                s1_q[g] <= pin_i[g];
                s2_q[g] <= s1_q[g];
            end
        end
    end

    assign lvl      = s2_q[src_sel_i] ^ invert_i;
    assign edge_hit = lvl && !prev_q;

    // Purpose: previous polarity-adjusted level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign term_w  = ((PS_W+1)'(1) << ({1'b0, div_exp_i} + (DW+1)'(1))) - (PS_W+1)'(1);
    assign ps_last = (ps_q == term_w[PS_W-1:0]);

    // Purpose: prescaler counter, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)          ps_q <= '0;
        else if (tick_i && !bypass_i)  ps_q <= ps_last ? '0 : ps_q + PS_W'(1);
    end

    assign step_o = run_i && (pulse_mode_i ? edge_hit : (tick_i && (bypass_i || ps_last)));

    // R11
    one_step_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode_i && step_o) |=> !step_o);
endmodule

// File: rtl/evt_timer_core.sv
// Counter and match flag: advances on each step, sets the flag on a step
// taken at the match value, and either zeroes or wraps the count.
module evt_timer_core #(
    parameter int W = evt_timer_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         free_run_i,
    input  logic         step_i,
    input  logic [W-1:0] cmp_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         flag_o
);
    logic [W-1:0] cnt_q;
    logic         flag_q, hit;

    assign hit = step_i && (cnt_q == cmp_i);

    // Purpose: event counter, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)          cnt_q <= '0;
        else if (hit && !free_run_i)   cnt_q <= '0;
        else if (step_i)               cnt_q <= cnt_q + W'(1);
    end

    // Purpose: sticky match flag, set wins over software clear
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) flag_q <= 1'b0;
        else if (hit)         flag_q <= 1'b1;
        else if (clr_i)       flag_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    // R2
    stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0) && !flag_q);

    // R5
    match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !free_run_i) |=> (cnt_q == '0) && flag_q);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && step_i && free_run_i && (cnt_q == '1)) |=> (cnt_q == '0));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_q);
endmodule

// File: rtl/evt_timer.sv
// Top: dual-mode event timer. Wires the register file, the step source
// and the counter core; raises the interrupt from flag and enable.
module evt_timer
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              tick_i,
    input  logic [NUM_IN-1:0] pulse_i,
    output logic              irq_o
);
    logic             run, irq_en, clr, step, flag;
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp, cnt;

    evt_timer_regs #(.W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .flag_i(flag), .cnt_i(cnt), .run_o(run),
        .irq_en_o(irq_en), .cfg_o(cfg), .cmp_o(cmp), .clr_o(clr),
        .rdata_o(reg_rdata)
    );

    evt_timer_src #(.N_IN(NUM_IN), .SW(SEL_W), .DW(DIV_W)) src_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .pulse_mode_i(cfg.pulse_mode),
        .invert_i(cfg.invert), .src_sel_i(cfg.src_sel), .bypass_i(cfg.bypass),
        .div_exp_i(cfg.div_exp), .tick_i(tick_i), .pin_i(pulse_i), .step_o(step)
    );

    evt_timer_core #(.W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .free_run_i(cfg.free_run),
        .step_i(step), .cmp_i(cmp), .clr_i(clr), .cnt_o(cnt), .flag_o(flag)
    );

    assign irq_o = flag && irq_en;
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tick_i = 1'b0;
    logic [3:0]  pulse_i = '0;
    logic        irq_o;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    evt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
        .pulse_i(pulse_i), .irq_o(irq_o)
    );

    function automatic logic [15:0] ctl(input logic run, mode, wrap, inv,
                                        input logic [1:0] sel, input logic ie, fl);
        return {8'h00, fl, ie, sel, inv, wrap, mode, run};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic pulse_edges(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            pulse_i[k] = ~pulse_i[k];
            repeat (6) @(negedge clk);
            pulse_i[k] = ~pulse_i[k];
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(2'd0, v); chk("R1 ctrl reset", v, 16'h0000);
        rd(2'd3, v); chk("R2 count reset", v, 16'h0000);
        chk("R8 irq reset", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_raw_ticks;
        logic [15:0] v;
        wr(2'd1, 16'h0010);                     // bypass
        wr(2'd2, 16'h1000);
        wr(2'd0, ctl(1,0,0,0,2'd0,0,0));
        ticks(7);
        rd(2'd3, v); chk("R3 raw tick count", v, 16'd7);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
        rd(2'd3, v); chk("R2 stop clears count", v, 16'd0);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        wr(2'd1, 16'h0001);                     // N=1 -> /4
        wr(2'd0, ctl(1,0,0,0,2'd0,0,0));
        ticks(10);
        rd(2'd3, v); chk("R4 divide by 4", v, 16'd2);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
        wr(2'd1, 16'h0010);
    endtask

    task automatic t_match_zero;
        logic [15:0] v;
        wr(2'd2, 16'd3);
        wr(2'd0, ctl(1,0,0,0,2'd0,1,0));
        ticks(3);
        rd(2'd0, v); chk("R5 no flag before match step", {15'd0, v[7]}, 16'd0);
        ticks(1);
        rd(2'd3, v); chk("R5 count zeroed on match", v, 16'd0);
        rd(2'd0, v); chk("R5 flag set on match", {15'd0, v[7]}, 16'd1);
        chk("R8 irq with enable", {15'd0, irq_o}, 16'd1);
        ticks(2);
        rd(2'd3, v); chk("R5 count resumes", v, 16'd2);
        wr(2'd0, ctl(1,0,0,0,2'd0,1,0));
        rd(2'd0, v); chk("R7 write 0 keeps flag", {15'd0, v[7]}, 16'd1);
        wr(2'd0, ctl(1,0,0,0,2'd0,0,0));
        chk("R8 irq masked", {15'd0, irq_o}, 16'd0);
        wr(2'd0, ctl(1,0,0,0,2'd0,1,1));
        rd(2'd0, v); chk("R7 write 1 clears flag", {15'd0, v[7]}, 16'd0);
        chk("R8 irq drops", {15'd0, irq_o}, 16'd0);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
    endtask

    task automatic t_free_wrap;
        logic [15:0] v;
        wr(2'd2, 16'd2);
        wr(2'd0, ctl(0,0,1,0,2'd0,0,0));
        wr(2'd0, ctl(1,0,0,0,2'd0,0,0));       // keeps wrap=1
        ticks(3);
        rd(2'd3, v); chk("R6 count passes match", v, 16'd3);
        rd(2'd0, v); chk("R6 flag set", {15'd0, v[7]}, 16'd1);
        ticks(65533);
        rd(2'd3, v); chk("R6 wrap to zero", v, 16'd0);
        rd(2'd0, v); chk("R6 flag stays", {15'd0, v[7]}, 16'd1);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
        rd(2'd0, v); chk("R2 stop clears flag", {15'd0, v[7]}, 16'd0);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
    endtask

    task automatic t_pulse_rise;
        logic [15:0] v;
        wr(2'd2, 16'hFFFF);
        wr(2'd0, ctl(0,1,0,0,2'd2,0,0));
        wr(2'd0, ctl(1,0,0,0,2'd0,0,0));
        pulse_edges(2, 3);
        pulse_edges(0, 2);
        pulse_edges(3, 2);
        rd(2'd3, v); chk("R9 select 2 counts only its edges", v, 16'd3);
        pulse_i[2] = 1'b1;
        repeat (40) @(negedge clk);
        rd(2'd3, v); chk("R11 held level counts once", v, 16'd4);
        pulse_i[2] = 1'b0;
        repeat (6) @(negedge clk);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
    endtask

    task automatic t_pulse_fall;
        logic [15:0] v;
        pulse_i[1] = 1'b1;
        wr(2'd0, ctl(0,1,0,1,2'd1,0,0));
        repeat (6) @(negedge clk);
        wr(2'd0, ctl(1,0,0,0,2'd0,0,0));
        pulse_i[1] = 1'b0; repeat (6) @(negedge clk);
        rd(2'd3, v); chk("R10 falling edge counted", v, 16'd1);
        pulse_i[1] = 1'b1; repeat (6) @(negedge clk);
        rd(2'd3, v); chk("R10 rising edge ignored", v, 16'd1);
        pulse_i[1] = 1'b0; repeat (6) @(negedge clk);
        rd(2'd3, v); chk("R10 second fall", v, 16'd2);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
    endtask

    task automatic t_lock;
        logic [15:0] v;
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
        wr(2'd0, ctl(1,1,1,1,2'd3,0,0));       // start with config change
        rd(2'd0, v); chk("R13 start ignores config", v, ctl(1,0,0,0,2'd0,0,0));
        wr(2'd0, ctl(1,1,0,0,2'd1,1,0));       // change while running
        rd(2'd0, v); chk("R12 running ignores config", v, ctl(1,0,0,0,2'd0,1,0));
        wr(2'd1, 16'h0003);
        rd(2'd1, v); chk("R12 prescale locked", v, 16'h0010);
        ticks(5);
        rd(2'd3, v); chk("R12 still tick mode", v, 16'd5);
        wr(2'd0, ctl(0,0,0,0,2'd0,0,0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw_ticks();
        t_prescale();
        t_match_zero();
        t_free_wrap();
        t_pulse_rise();
        t_pulse_fall();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule